// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Timer

This block generates eight edge-aligned pulse-width-modulated outputs from one shared 16-bit up-counter. Software reaches the block through a small register bus with a write strobe and a read strobe. A status/control register picks which tick stream advances the counter and sets a power-of-two prescaler on it. The counter runs from a programmable start value up to a common modulo value, so every channel has the same period. Each channel compares the count against its own compare value.

Each channel has a mode/control register that enables edge-aligned output. A channel that is not in that mode drives a static level taken from an output-initial register. Per-channel polarity bits invert the outputs. Per-channel mask bits hold an output at its inactive level. After reset every channel is masked. Writes to the modulo and compare registers are first held in buffers. They reach the running logic only when the counter wraps, or when software writes the counter register. A period in progress therefore always runs to its end.

Top module: `pwm8_timer`

## Requirements
- R1: After reset, every bit of `pwm_o` is 0. The output-mask register (0x60) reads 0xFF. The status/control (0x00), counter (0x04), modulo (0x08), start-value (0x4C), output-initial (0x5C) and polarity (0x70) registers all read 0.
- R2: Bits 4:3 of the status/control register choose the counter tick source: 0 stops the counter, 1 ticks on every clock, 2 ticks on `fix_tick_i`, 3 ticks on `ext_tick_i`. Ticks from any source other than the selected one have no effect.
- R3: Bits 2:0 of the status/control register hold PS. The counter advances once per 2^PS selected ticks. A write to the counter register clears the prescaler phase, and the first advance then comes on the 2^PS-th tick.
- R4: The 16-bit counter counts up by one per advance. On the advance taken at or above the active modulo value, it returns to the start value (0x4C). With a start value of 0, one period is modulo+1 advances.
- R5: A read of 0x04 returns the live count. Any write to 0x04 reloads the counter with the start value, regardless of the data written.
- R6: When a channel's control register (0x0C + 8*n) has both bit 5 and bit 3 set, the channel's level is high while the count is below its active compare value and low from the match to the end of the period. A compare value of 0 gives a constant low. A compare value above the modulo gives a constant high.
- R7: When a channel's control register does not have both bit 5 and bit 3 set, the channel's level is bit n of the output-initial register (0x5C).
- R8: Bit n of the polarity register (0x70) inverts channel n's level on `pwm_o[n]`.
- R9: When bit n of the output-mask register (0x60) is set, `pwm_o[n]` is held at its inactive level, which equals polarity bit n.
- R10: A write to the modulo register (0x08) or to a channel compare register (0x10 + 8*n) goes into a buffer. A read of that register returns the buffered value. The buffered values become active only when the counter wraps or when the counter register is written.
- R11: Read data appears on `bus_rdata_o` after the clock edge on which `bus_rd_i` is sampled high, and stays there until the next read. A read of an address with no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fix_tick_i | input | 1 | Tick stream for clock-source code 2, one tick per cycle it is high |
| ext_tick_i | input | 1 | Tick stream for clock-source code 3, one tick per cycle it is high |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pwm_o | output | 8 | Channel outputs |

## Verification
A table drives the channels with a range of compare values: zero, mid-period, equal to the modulo, and above the modulo. Each of these is combined with polarity and mask settings. The bench counts high cycles across exactly one period, which tells a correct duty apart from off-by-one comparisons. It also checks the level in the first cycle after restart, which separates edge-aligned high-first output from inverted or shifted output. Directed sequences change the modulo in the middle of a period and check that the current period still runs to its old end. Further sequences use each clock source and a nonzero prescaler to show that only the chosen ticks count. A start value with a short modulo shows that the counter wraps back to the start value and not to zero.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } cnt_src_e;

  // register byte offsets
  localparam logic [7:0] A_SC     = 8'h00;
  localparam logic [7:0] A_CNT    = 8'h04;
  localparam logic [7:0] A_MOD    = 8'h08;
  localparam logic [7:0] A_CH0    = 8'h0C;
  localparam int         CH_STRIDE = 8;
  localparam logic [2:0] CH_CTL_REL = 3'd0;
  localparam logic [2:0] CH_CMP_REL = 3'd4;
  localparam logic [7:0] A_START  = 8'h4C;
  localparam logic [7:0] A_OINIT  = 8'h5C;
  localparam logic [7:0] A_MASK   = 8'h60;
  localparam logic [7:0] A_POL    = 8'h70;

  // field positions
  localparam int SC_SRC_LSB   = 3;
  localparam int SC_W         = 5;
  localparam int CTL_W        = 8;
  localparam int CTL_EDGE_BIT = 5;
  localparam int CTL_HIGH_BIT = 3;

endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs
  import pwm8_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [CNT_W-1:0]    cnt_live,
  output logic [DATA_W-1:0]   rdata,
  output cnt_src_e            src,
  output logic [PS_W-1:0]     ps,
  output logic [CNT_W-1:0]    mod_buf,
  output logic [CNT_W-1:0]    start_val,
  output logic                cnt_wr,
  output logic [CNT_W-1:0]    cmp_buf [NUM_CH],
  output logic [NUM_CH-1:0]   edge_mode,
  output logic [NUM_CH-1:0]   oinit,
  output logic [NUM_CH-1:0]   mask,
  output logic [NUM_CH-1:0]   pol
);

  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CH_SPAN  = NUM_CH * CH_STRIDE;

  logic [SC_W-1:0]   sc_q, sc_d;
  logic [CNT_W-1:0]  mod_q, mod_d;
  logic [CNT_W-1:0]  start_q, start_d;
  logic [NUM_CH-1:0] oinit_q, oinit_d;
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic [NUM_CH-1:0] pol_q, pol_d;
  logic [CTL_W-1:0]  ctl_q [NUM_CH];
  logic [CTL_W-1:0]  ctl_d [NUM_CH];
  logic [CNT_W-1:0]  cmp_q [NUM_CH];
  logic [CNT_W-1:0]  cmp_d [NUM_CH];
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // channel window decode
  logic [ADDR_W-1:0]   ch_off;
  logic                in_ch;
  logic [CH_IDX_W-1:0] ch_sel;
  logic                ctl_hit;
  logic                cmp_hit;

  always_comb begin
    ch_off  = addr - ADDR_W'(A_CH0);
    in_ch   = (addr >= ADDR_W'(A_CH0)) && (ch_off < ADDR_W'(CH_SPAN));
    ch_sel  = ch_off[3 +: CH_IDX_W];
    ctl_hit = in_ch && (ch_off[2:0] == CH_CTL_REL);
    cmp_hit = in_ch && (ch_off[2:0] == CH_CMP_REL);
  end

  // write next-state
  always_comb begin
    sc_d    = sc_q;
    mod_d   = mod_q;
    start_d = start_q;
    oinit_d = oinit_q;
    mask_d  = mask_q;
    pol_d   = pol_q;
    cnt_wr  = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      ctl_d[i] = ctl_q[i];
      cmp_d[i] = cmp_q[i];
    end
    if (wr) begin
      if (addr == ADDR_W'(A_SC))         sc_d    = wdata[SC_W-1:0];
      else if (addr == ADDR_W'(A_CNT))   cnt_wr  = 1'b1;
      else if (addr == ADDR_W'(A_MOD))   mod_d   = wdata[CNT_W-1:0];
      else if (addr == ADDR_W'(A_START)) start_d = wdata[CNT_W-1:0];
      else if (addr == ADDR_W'(A_OINIT)) oinit_d = wdata[NUM_CH-1:0];
      else if (addr == ADDR_W'(A_MASK))  mask_d  = wdata[NUM_CH-1:0];
      else if (addr == ADDR_W'(A_POL))   pol_d   = wdata[NUM_CH-1:0];
      for (int i = 0; i < NUM_CH; i++) begin
        if (ctl_hit && (ch_sel == CH_IDX_W'(i))) ctl_d[i] = wdata[CTL_W-1:0];
        if (cmp_hit && (ch_sel == CH_IDX_W'(i))) cmp_d[i] = wdata[CNT_W-1:0];
      end
    end
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    if (addr == ADDR_W'(A_SC))         rdata_d[SC_W-1:0]   = sc_q;
    else if (addr == ADDR_W'(A_CNT))   rdata_d[CNT_W-1:0]  = cnt_live;
    else if (addr == ADDR_W'(A_MOD))   rdata_d[CNT_W-1:0]  = mod_q;
    else if (addr == ADDR_W'(A_START)) rdata_d[CNT_W-1:0]  = start_q;
    else if (addr == ADDR_W'(A_OINIT)) rdata_d[NUM_CH-1:0] = oinit_q;
    else if (addr == ADDR_W'(A_MASK))  rdata_d[NUM_CH-1:0] = mask_q;
    else if (addr == ADDR_W'(A_POL))   rdata_d[NUM_CH-1:0] = pol_q;
    else if (ctl_hit)                  rdata_d[CTL_W-1:0]  = ctl_q[ch_sel];
    else if (cmp_hit)                  rdata_d[CNT_W-1:0]  = cmp_q[ch_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q    <= '0;
      mod_q   <= '0;
      start_q <= '0;
      oinit_q <= '0;
      mask_q  <= '1;
      pol_q   <= '0;
      rdata_q <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        ctl_q[i] <= '0;
        cmp_q[i] <= '0;
      end
    end else begin
      sc_q    <= sc_d;
      mod_q   <= mod_d;
      start_q <= start_d;
      oinit_q <= oinit_d;
      mask_q  <= mask_d;
      pol_q   <= pol_d;
      for (int i = 0; i < NUM_CH; i++) begin
        ctl_q[i] <= ctl_d[i];
        cmp_q[i] <= cmp_d[i];
      end
      if (rd) rdata_q <= rdata_d;
    end
  end

  always_comb begin
    rdata     = rdata_q;
    src       = cnt_src_e'(sc_q[SC_SRC_LSB +: 2]);
    ps        = sc_q[PS_W-1:0];
    mod_buf   = mod_q;
    start_val = start_q;
    oinit     = oinit_q;
    mask      = mask_q;
    pol       = pol_q;
    for (int i = 0; i < NUM_CH; i++) begin
      cmp_buf[i]   = cmp_q[i];
      edge_mode[i] = ctl_q[i][CTL_EDGE_BIT] & ctl_q[i][CTL_HIGH_BIT];
    end
  end

endmodule

// File: rtl/pwm8_tick.sv
module pwm8_tick
  import pwm8_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cnt_src_e        src,
  input  logic [PS_W-1:0] ps,
  input  logic            fix_tick,
  input  logic            ext_tick,
  input  logic            clr,
  output logic            cnt_en
);

  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d, pre_mask;
  logic             tick;

  always_comb begin
    case (src)
      SRC_SYS: tick = 1'b1;
      SRC_FIX: tick = fix_tick;
      SRC_EXT: tick = ext_tick;
      default: tick = 1'b0;
    endcase
    pre_mask = ~({PRE_W{1'b1}} << ps);
    cnt_en   = tick && ((pre_q & pre_mask) == pre_mask);
    if (clr)       pre_d = '0;
    else if (tick) pre_d = pre_q + 1'b1;
    else           pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // after one advance, the next cycle can advance again only when undivided
  assert_ps_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && ps != '0) |=> (!cnt_en || ps == '0))
    else $error("prescaled advance in consecutive cycles");

endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] mod_buf,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] cnt,
  output logic             load
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mod_q, mod_d;
  logic             at_end;

  always_comb begin
    at_end = (cnt_q >= mod_q);
    load   = cnt_wr | (cnt_en & at_end);
    if (cnt_wr)      cnt_d = start_val;
    else if (cnt_en) cnt_d = at_end ? start_val : cnt_q + 1'b1;
    else             cnt_d = cnt_q;
    mod_d = load ? mod_buf : mod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mod_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      mod_q <= mod_d;
    end
  end

  assign cnt = cnt_q;

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_wr) |=> ((cnt_q == CNT_W'($past(cnt_q) + 1'b1)) || (cnt_q == $past(start_val))))
    else $error("counter advanced to an unexpected value");

  assert_cnt_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(start_val)))
    else $error("counter write did not reload the start value");

  assert_mod_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mod_q))
    else $error("active modulo changed outside a wrap");

endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_buf,
  input  logic             edge_mode,
  input  logic             oinit_bit,
  input  logic             mask_bit,
  input  logic             pol_bit,
  output logic             pwm_out
);

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             level;

  always_comb begin
    cmp_d   = load ? cmp_buf : cmp_q;
    level   = edge_mode ? (cnt < cmp_q) : oinit_bit;
    pwm_out = mask_bit ? pol_bit : (level ^ pol_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_d;
  end

  assert_cmp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cmp_q))
    else $error("active compare changed outside a wrap");

  assert_zero_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && cmp_q == '0) |-> (pwm_out == pol_bit))
    else $error("zero compare produced an active level");

endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
  import pwm8_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fix_tick_i,
  input  logic              ext_tick_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_s2, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_sync_n = rst_s2;

  cnt_src_e          src;
  logic [PS_W-1:0]   ps;
  logic [CNT_W-1:0]  mod_buf, start_val, cnt;
  logic              cnt_wr, cnt_en, load;
  logic [CNT_W-1:0]  cmp_buf [NUM_CH];
  logic [NUM_CH-1:0] edge_mode, oinit, mask, pol;

  pwm8_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PS_W(PS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr(bus_wr_i), .rd(bus_rd_i), .addr(bus_addr_i), .wdata(bus_wdata_i),
    .cnt_live(cnt), .rdata(bus_rdata_o),
    .src(src), .ps(ps), .mod_buf(mod_buf), .start_val(start_val), .cnt_wr(cnt_wr),
    .cmp_buf(cmp_buf), .edge_mode(edge_mode), .oinit(oinit), .mask(mask), .pol(pol)
  );

  pwm8_tick #(.PS_W(PS_W)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .src(src), .ps(ps),
    .fix_tick(fix_tick_i), .ext_tick(ext_tick_i), .clr(cnt_wr), .cnt_en(cnt_en)
  );

  pwm8_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en), .cnt_wr(cnt_wr),
    .mod_buf(mod_buf), .start_val(start_val), .cnt(cnt), .load(load)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm8_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .load(load), .cnt(cnt),
      .cmp_buf(cmp_buf[g]), .edge_mode(edge_mode[g]), .oinit_bit(oinit[g]),
      .mask_bit(mask[g]), .pol_bit(pol[g]), .pwm_out(pwm_o[g])
    );

    assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      mask[g] |-> (pwm_o[g] == pol[g]))
      else $error("masked channel left its inactive level");
  end

  assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (src == SRC_OFF && !cnt_wr) |=> $stable(cnt))
    else $error("counter moved with the source stopped");

endmodule

// File: tb/tb_pwm8_timer.sv
module tb_pwm8_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fix_tick_i, ext_tick_i;
  logic        bus_wr_i, bus_rd_i;
  logic [7:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic [7:0]  pwm_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pwm8_timer dut (
    .clk(clk), .rst_n(rst_n), .fix_tick_i(fix_tick_i), .ext_tick_i(ext_tick_i),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .pwm_o(pwm_o)
  );

  localparam logic [7:0] R_SC = 8'h00, R_CNT = 8'h04, R_MOD = 8'h08, R_START = 8'h4C,
                         R_OINIT = 8'h5C, R_MASK = 8'h60, R_POL = 8'h70;

  typedef struct packed {
    logic [15:0] modv;
    logic [15:0] cmp;
    logic        pol;
    logic        msk;
    logic [15:0] highs;
    logic        first;
  } vec_t;

  // channel n = entry index
  localparam vec_t VECS [8] = '{
    '{16'd9,  16'd3,  1'b0, 1'b0, 16'd3,  1'b1},
    '{16'd9,  16'd0,  1'b0, 1'b0, 16'd0,  1'b0},
    '{16'd9,  16'd10, 1'b0, 1'b0, 16'd10, 1'b1},
    '{16'd9,  16'd9,  1'b0, 1'b0, 16'd9,  1'b1},
    '{16'd4,  16'd2,  1'b1, 1'b0, 16'd3,  1'b0},
    '{16'd7,  16'd5,  1'b0, 1'b1, 16'd0,  1'b0},
    '{16'd7,  16'd5,  1'b1, 1'b1, 16'd8,  1'b1},
    '{16'd15, 16'd16, 1'b1, 1'b0, 16'd0,  1'b0}
  };

  function automatic logic [7:0] ctl_addr(int ch);
    return 8'(8'h0C + 8 * ch);
  endfunction

  function automatic logic [7:0] cmp_addr(int ch);
    return 8'(8'h10 + 8 * ch);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    bus_addr_i  = a;
    bus_wdata_i = d;
    bus_wr_i    = 1'b1;
    @(negedge clk);
    bus_wr_i    = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    bus_addr_i = a;
    bus_rd_i   = 1'b1;
    @(negedge clk);
    bus_rd_i   = 1'b0;
    d          = bus_rdata_o;
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv, rv2;
    int          highs;
    int          ch;
    logic [7:0]  ok_pat [6];

    rst_n = 1'b0;
    fix_tick_i = 1'b0; ext_tick_i = 1'b0;
    bus_wr_i = 1'b0; bus_rd_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(4);

    // R1 reset state
    check("R1 pwm_o", {24'd0, pwm_o}, 32'd0);
    bus_read(R_MASK, rv);  check("R1 mask", rv, 32'hFF);
    bus_read(R_SC, rv);    check("R1 sc", rv, 32'd0);
    bus_read(R_CNT, rv);   check("R1 cnt", rv, 32'd0);
    bus_read(R_MOD, rv);   check("R1 mod", rv, 32'd0);
    bus_read(R_START, rv); check("R1 start", rv, 32'd0);
    bus_read(R_OINIT, rv); check("R1 oinit", rv, 32'd0);
    bus_read(R_POL, rv);   check("R1 pol", rv, 32'd0);
    // R11 unmapped
    bus_read(8'h7C, rv);   check("R11 unmapped", rv, 32'd0);

    // table: R6 R8 R9 R4
    for (int i = 0; i < 8; i++) begin
      ch = i;
      bus_write(R_SC, 32'h00);
      bus_write(R_MOD, {16'd0, VECS[i].modv});
      bus_write(cmp_addr(ch), {16'd0, VECS[i].cmp});
      bus_write(ctl_addr(ch), 32'h28);
      bus_write(R_POL, 32'(VECS[i].pol) << ch);
      bus_write(R_MASK, VECS[i].msk ? 32'hFF : {24'd0, ~(8'h01 << ch)});
      bus_write(R_CNT, 32'd0);
      bus_write(R_SC, 32'h08);
      highs = 0;
      for (int k = 0; k <= int'(VECS[i].modv); k++) begin
        if (k == 0) check("R6 first level after restart", {31'd0, pwm_o[ch]}, {31'd0, VECS[i].first});
        if (pwm_o[ch]) highs++;
        @(negedge clk);
      end
      check("R6/R8/R9 highs per period", highs, {16'd0, VECS[i].highs});
    end

    // R11 compare readback returns buffered value
    bus_read(cmp_addr(3), rv); check("R11 R10 compare readback", rv, 32'd9);

    // R10 buffered modulo: change mid-period
    bus_write(R_SC, 32'h00);
    bus_write(R_MOD, 32'd9);
    bus_write(cmp_addr(0), 32'd8);
    bus_write(ctl_addr(0), 32'h28);
    bus_write(R_POL, 32'h00);
    bus_write(R_MASK, 32'hFE);
    bus_write(R_CNT, 32'd0);
    bus_write(R_SC, 32'h08);
    wait_cycles(3);                 // count 3
    bus_write(R_MOD, 32'd4);        // count now 4
    ok_pat = '{8'd1, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0};
    for (int k = 0; k < 6; k++) begin
      check("R10 old period completes", {31'd0, pwm_o[0]}, {24'd0, ok_pat[k]});
      @(negedge clk);
    end
    highs = 0;
    for (int k = 0; k < 10; k++) begin
      if (pwm_o[0]) highs++;
      @(negedge clk);
    end
    check("R10 new modulo after wrap R6 compare above modulo", highs, 10);
    bus_read(R_MOD, rv); check("R10 modulo readback", rv, 32'd4);

    // R3 prescaler 2^2
    bus_write(R_SC, 32'h00);
    bus_write(R_MOD, 32'hFFFF);
    bus_write(R_CNT, 32'd0);
    bus_write(R_SC, 32'h0A);
    wait_cycles(20);
    bus_read(R_CNT, rv); check("R3 divide by four", rv, 32'd5);

    // R4 R5 start value and wrap
    bus_write(R_SC, 32'h00);
    bus_write(R_START, 32'd100);
    bus_write(R_MOD, 32'd103);
    bus_write(R_CNT, 32'd0);
    bus_write(R_SC, 32'h08);
    wait_cycles(6);
    bus_read(R_CNT, rv); check("R4 wrap to start value", rv, 32'd102);
    bus_write(R_CNT, 32'h1234);
    bus_read(R_CNT, rv); check("R5 write reloads start", rv, 32'd100);

    // R2 fixed source
    bus_write(R_SC, 32'h00);
    bus_write(R_START, 32'd0);
    bus_write(R_MOD, 32'hFFFF);
    bus_write(R_CNT, 32'd0);
    bus_write(R_SC, 32'h10);
    fix_tick_i = 1'b1; ext_tick_i = 1'b1;
    wait_cycles(3);
    fix_tick_i = 1'b0;
    wait_cycles(2);
    ext_tick_i = 1'b0;
    bus_read(R_CNT, rv); check("R2 fixed ticks only", rv, 32'd3);

    // R2 external source
    bus_write(R_SC, 32'h18);
    bus_write(R_CNT, 32'd0);
    ext_tick_i = 1'b1;
    wait_cycles(4);
    ext_tick_i = 1'b0; fix_tick_i = 1'b1;
    wait_cycles(2);
    fix_tick_i = 1'b0;
    bus_read(R_CNT, rv); check("R2 external ticks only", rv, 32'd4);

    // R2 stop
    bus_write(R_SC, 32'h08);
    wait_cycles(3);
    bus_write(R_SC, 32'h00);
    bus_read(R_CNT, rv);
    wait_cycles(5);
    bus_read(R_CNT, rv2); check("R2 source zero holds count", rv2, rv);

    // R7 static level outside edge mode
    bus_write(R_CNT, 32'd0);
    bus_write(cmp_addr(2), 32'd5);
    bus_write(ctl_addr(2), 32'h00);
    bus_write(R_OINIT, 32'h04);
    bus_write(R_POL, 32'h00);
    bus_write(R_MASK, 32'h00);
    bus_write(R_CNT, 32'd0);
    check("R7 output-initial level high", {31'd0, pwm_o[2]}, 32'd1);
    bus_write(R_OINIT, 32'h00);
    bus_write(ctl_addr(2), 32'h20);
    check("R7 partial mode uses output-initial", {31'd0, pwm_o[2]}, 32'd0);
    bus_write(ctl_addr(2), 32'h28);
    check("R6 edge mode below compare", {31'd0, pwm_o[2]}, 32'd1);
    bus_write(R_POL, 32'h04);
    check("R8 inverted level", {31'd0, pwm_o[2]}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule